// File: doc/BRIEF.md
# Overlay Palette Mixer with Soft Edges

This block places a per-pixel overlay colour on top of a 4:4:4 YCbCr pixel stream, one pixel per clock at most. Each accepted pixel carries a 3-bit overlay code and a 2-bit mix level. Code zero means "keep the pixel". Each nonzero code picks one of seven fixed colour-bar colours. A static 2-bit mode input chooses how the overlay colour and the pixel are combined. The mix can be turned off. It can follow the per-pixel mix level. It can replace the pixel outright. Or it can soften the edges of overlay regions by itself, which it does by looking one pixel ahead at the next overlay code.

To allow that lookahead, the block holds each pixel in a one-entry stage. It emits the result for pixel n in the clock after pixel n+1 is accepted. This latency is the same in every mode. The output is registered, and `out_valid` marks each result. All blends use eighth steps and are built from shifts and adds.

Top module: `ovl_mixer_top`

## Requirements
- R1: While `rst` is high and in the first clock after it falls, `out_valid` is low. After reset, the first accepted pixel produces no output on its own.
- R2: The result for accepted pixel n is presented with `out_valid` high in the clock after pixel n+1 is accepted. When `in_valid` is low, `out_valid` is low in the next clock. This latency is the same in all four modes.
- R3: Overlay codes 1 to 7 select the fixed colours (Y,Cb,Cr). Code 1 is blue 75% (35,212,114). Code 2 is red 75% (65,100,212). Code 3 is magenta 75% (84,184,198). Code 4 is green 75% (112,72,58). Code 5 is cyan 75% (131,156,44). Code 6 is yellow 75% (162,44,142). Code 7 is white 100% (235,128,128).
- R4: With `mode` = 00 (off), the output equals the input pixel, whatever the overlay code and mix level are.
- R5: With `mode` = 01 (external), a nonzero code blends the overlay colour into the pixel. The mix level sets the overlay share: 00 gives 0/8, 01 gives 1/8, 10 gives 7/8 and 11 gives 8/8. Each component is (w·overlay + (8−w)·pixel + 4) >> 3. The level may change on any pixel.
- R6: With `mode` = 01, a pixel whose code is 0 is output unchanged, whatever its mix level is.
- R7: With `mode` = 11 (hard), a nonzero code outputs the palette colour exactly, and code 0 outputs the pixel.
- R8: With `mode` = 10 (internal), when the code goes from 0 to an overlay colour, the last pixel before the change gets 1/8 of that colour. The first overlay pixel gets 7/8, and later overlay pixels get the colour in full.
- R9: With `mode` = 10, when the code goes from an overlay colour to 0, the last overlay pixel keeps 7/8 of the colour and 1/8 of the pixel. The next pixel keeps 1/8 of the colour. Later pixels are unchanged.
- R10: With `mode` = 10, when the code goes from one overlay colour to another, the results are 1/8 new with 7/8 old one pixel early, then 7/8 new with 1/8 old, then the new colour in full. Each overlay run must be at least three pixels long.
- R11: With `mode` = 10, the mix-level input has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 off, 01 external, 10 internal, 11 hard |
| in_valid | input | 1 | Pixel, code and level are accepted this clock |
| in_y | input | DW | Luma of the incoming pixel |
| in_cb | input | DW | Blue colour difference of the incoming pixel |
| in_cr | input | DW | Red colour difference of the incoming pixel |
| in_code | input | 3 | Overlay code, 0 = pixel |
| in_lvl | input | 2 | Per-pixel mix level (external mode) |
| out_valid | output | 1 | A mixed pixel is presented |
| out_y | output | DW | Mixed luma |
| out_cb | output | DW | Mixed blue colour difference |
| out_cr | output | DW | Mixed red colour difference |

## Verification
The assertions check on every cycle that output is quiet after reset and that each result follows an accepted pixel. They also check three cases against the staged pixel or the palette: off mode passes the pixel through, external mode passes code-zero pixels through, and hard mode outputs the palette colour. The rounded eighth-step blends, the one-pixel-early edges in internal mode and the fact that the mix level has no effect there all depend on pixel sequences. Only the bench's scenarios show them: it runs edges from pixel to overlay, from overlay to pixel and between two colours, with mix levels that change.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef enum logic [1:0] {
    MD_OFF  = 2'b00,
    MD_EXT  = 2'b01,
    MD_INT  = 2'b10,
    MD_HARD = 2'b11
  } mode_e;

  // overlay share in eighths: 0, 1, 7 or 8
  typedef enum logic [1:0] {
    WT_NONE   = 2'b00,
    WT_EIGHTH = 2'b01,
    WT_SEVEN  = 2'b10,
    WT_FULL   = 2'b11
  } wt_e;

  // fixed colour-bar palette as 8-bit {Y, Cb, Cr}
  function automatic logic [23:0] bar_color(input logic [2:0] code);
    logic [23:0] c;
    case (code)
      3'd1:    c = {8'd35,  8'd212, 8'd114};
      3'd2:    c = {8'd65,  8'd100, 8'd212};
      3'd3:    c = {8'd84,  8'd184, 8'd198};
      3'd4:    c = {8'd112, 8'd72,  8'd58};
      3'd5:    c = {8'd131, 8'd156, 8'd44};
      3'd6:    c = {8'd162, 8'd44,  8'd142};
      3'd7:    c = {8'd235, 8'd128, 8'd128};
      default: c = {8'd16,  8'd128, 8'd128};
    endcase
    return c;
  endfunction

  function automatic wt_e lvl_to_wt(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return WT_NONE;
      2'b01:   return WT_EIGHTH;
      2'b10:   return WT_SEVEN;
      default: return WT_FULL;
    endcase
  endfunction

endpackage

// File: rtl/ovl_color_src.sv
module ovl_color_src #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic [CW-1:0] code,
  input  logic [DW-1:0] pix_y,
  input  logic [DW-1:0] pix_cb,
  input  logic [DW-1:0] pix_cr,
  output logic [DW-1:0] col_y,
  output logic [DW-1:0] col_cb,
  output logic [DW-1:0] col_cr
);
  import ovl_pkg::*;

  localparam int SH = DW - 8;

  logic [23:0] k;
  logic [DW-1:0] ky, kcb, kcr;

  assign k = bar_color(code[2:0]);

  generate
    if (SH == 0) begin : g_native
      assign ky  = k[23:16];
      assign kcb = k[15:8];
      assign kcr = k[7:0];
    end else begin : g_scaled
      assign ky  = {k[23:16], {SH{1'b0}}};
      assign kcb = {k[15:8],  {SH{1'b0}}};
      assign kcr = {k[7:0],   {SH{1'b0}}};
    end
  endgenerate

  always_comb begin
    if (code == '0) begin
      col_y  = pix_y;
      col_cb = pix_cb;
      col_cr = pix_cr;
    end else begin
      col_y  = ky;
      col_cb = kcb;
      col_cr = kcr;
    end
  end

endmodule

// File: rtl/ovl_stage.sv
module ovl_stage #(
  parameter int DW = 8,
  parameter int CW = 3,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  input  logic [CW-1:0] in_code,
  input  logic [LW-1:0] in_lvl,
  output logic          stg_full,
  output logic [DW-1:0] stg_y,
  output logic [DW-1:0] stg_cb,
  output logic [DW-1:0] stg_cr,
  output logic [CW-1:0] stg_code,
  output logic [LW-1:0] stg_lvl,
  output logic [CW-1:0] prv_code
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_full <= 1'b0;
      stg_y    <= '0;
      stg_cb   <= '0;
      stg_cr   <= '0;
      stg_code <= '0;
      stg_lvl  <= '0;
      prv_code <= '0;
    end else if (in_valid) begin
      stg_full <= 1'b1;
      stg_y    <= in_y;
      stg_cb   <= in_cb;
      stg_cr   <= in_cr;
      stg_code <= in_code;
      stg_lvl  <= in_lvl;
      prv_code <= stg_code;
    end
  end

endmodule

// File: rtl/ovl_wsel.sv
module ovl_wsel #(
  parameter int CW = 3,
  parameter int LW = 2
) (
  input  ovl_pkg::mode_e mode,
  input  logic [CW-1:0]  prv_code,
  input  logic [CW-1:0]  cur_code,
  input  logic [CW-1:0]  nxt_code,
  input  logic [LW-1:0]  cur_lvl,
  output logic [CW-1:0]  base_code,
  output logic [CW-1:0]  top_code,
  output ovl_pkg::wt_e   wt
);
  import ovl_pkg::*;

  always_comb begin
    base_code = '0;
    top_code  = cur_code;
    wt        = WT_NONE;
    case (mode)
      MD_EXT: begin
        if (cur_code != '0) wt = lvl_to_wt(cur_lvl[1:0]);
      end
      MD_HARD: begin
        if (cur_code != '0) wt = WT_FULL;
      end
      MD_INT: begin
        if (nxt_code != cur_code) begin
          // one pixel early: 1/8 of what comes next
          base_code = cur_code;
          top_code  = nxt_code;
          wt        = WT_EIGHTH;
        end else if (prv_code != cur_code) begin
          // first pixel after a change: 7/8 of the new colour
          base_code = prv_code;
          top_code  = cur_code;
          wt        = WT_SEVEN;
        end else begin
          base_code = cur_code;
          top_code  = cur_code;
          wt        = WT_NONE;
        end
      end
      default: begin
        top_code = '0;
        wt       = WT_NONE;
      end
    endcase
  end

endmodule

// File: rtl/ovl_mix.sv
module ovl_mix #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] top,
  input  ovl_pkg::wt_e  wt,
  output logic [DW-1:0] res
);
  import ovl_pkg::*;

  localparam int SW = DW + 3;

  logic [SW-1:0] b7, t7, lo_sum, hi_sum;

  // seven times a value as (x << 3) - x
  assign b7 = {base, 3'b000} - SW'(base);
  assign t7 = {top, 3'b000} - SW'(top);
  assign lo_sum = b7 + SW'(top) + SW'(4);
  assign hi_sum = SW'(base) + t7 + SW'(4);

  always_comb begin
    case (wt)
      WT_EIGHTH: res = lo_sum[SW-1:3];
      WT_SEVEN:  res = hi_sum[SW-1:3];
      WT_FULL:   res = top;
      default:   res = base;
    endcase
  end

endmodule

// File: rtl/ovl_mixer_top.sv
module ovl_mixer_top #(
  parameter int DW = 8,
  parameter int CW = 3,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          in_valid,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  input  logic [CW-1:0] in_code,
  input  logic [LW-1:0] in_lvl,
  output logic          out_valid,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr
);
  import ovl_pkg::*;

  localparam int NCOMP = 3;

  logic          stg_full;
  logic [DW-1:0] stg_y, stg_cb, stg_cr;
  logic [CW-1:0] stg_code, prv_code;
  logic [LW-1:0] stg_lvl;

  logic [CW-1:0] base_code, top_code;
  wt_e           wt;
  mode_e         mode_q;

  logic [DW-1:0] base_y, base_cb, base_cr;
  logic [DW-1:0] top_y, top_cb, top_cr;
  logic [DW-1:0] base_c [NCOMP];
  logic [DW-1:0] top_c  [NCOMP];
  logic [DW-1:0] mix_c  [NCOMP];

  assign mode_q = mode_e'(mode);

  ovl_stage #(.DW(DW), .CW(CW), .LW(LW)) u_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .in_code(in_code), .in_lvl(in_lvl),
    .stg_full(stg_full), .stg_y(stg_y), .stg_cb(stg_cb), .stg_cr(stg_cr),
    .stg_code(stg_code), .stg_lvl(stg_lvl), .prv_code(prv_code)
  );

  ovl_wsel #(.CW(CW), .LW(LW)) u_wsel (
    .mode(mode_q), .prv_code(prv_code), .cur_code(stg_code),
    .nxt_code(in_code), .cur_lvl(stg_lvl),
    .base_code(base_code), .top_code(top_code), .wt(wt)
  );

  ovl_color_src #(.DW(DW), .CW(CW)) u_base_src (
    .code(base_code), .pix_y(stg_y), .pix_cb(stg_cb), .pix_cr(stg_cr),
    .col_y(base_y), .col_cb(base_cb), .col_cr(base_cr)
  );

  ovl_color_src #(.DW(DW), .CW(CW)) u_top_src (
    .code(top_code), .pix_y(stg_y), .pix_cb(stg_cb), .pix_cr(stg_cr),
    .col_y(top_y), .col_cb(top_cb), .col_cr(top_cr)
  );

  assign base_c[0] = base_y;
  assign base_c[1] = base_cb;
  assign base_c[2] = base_cr;
  assign top_c[0]  = top_y;
  assign top_c[1]  = top_cb;
  assign top_c[2]  = top_cr;

  generate
    for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      ovl_mix #(.DW(DW)) u_mix (
        .base(base_c[k]), .top(top_c[k]), .wt(wt), .res(mix_c[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_cb    <= '0;
      out_cr    <= '0;
    end else begin
      out_valid <= stg_full & in_valid;
      if (stg_full && in_valid) begin
        out_y  <= mix_c[0];
        out_cb <= mix_c[1];
        out_cr <= mix_c[2];
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R2
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R4
  off_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mode) == MD_OFF) |->
      (out_y == $past(stg_y) && out_cb == $past(stg_cb) && out_cr == $past(stg_cr)));

  // R6
  ext_code0_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mode) == MD_EXT && $past(stg_code) == '0) |->
      (out_y == $past(stg_y) && out_cb == $past(stg_cb) && out_cr == $past(stg_cr)));

  // R7
  hard_palette_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mode) == MD_HARD && $past(stg_code) != '0) |->
      (out_y == $past(top_y) && out_cb == $past(top_cb) && out_cr == $past(top_cr)));

endmodule

// File: tb/tb_ovl_mixer_top.sv
module tb_ovl_mixer_top;

  localparam int DW = 8;
  // entry: {start, mode[1:0], code[2:0], lvl[1:0], y, cb, cr}
  localparam int NV = 37;
  localparam logic [31:0] VEC [NV] = '{
    // off mode (R4)
    {1'b1, 2'd0, 3'd3, 2'd2, 8'd50,  8'd60,  8'd70},
    {1'b0, 2'd0, 3'd7, 2'd3, 8'd200, 8'd10,  8'd240},
    {1'b0, 2'd0, 3'd0, 2'd1, 8'd16,  8'd128, 8'd128},
    {1'b0, 2'd0, 3'd5, 2'd0, 8'd90,  8'd100, 8'd110},
    // external mode (R5, R6)
    {1'b1, 2'd1, 3'd1, 2'd0, 8'd100, 8'd128, 8'd128},
    {1'b0, 2'd1, 3'd1, 2'd1, 8'd100, 8'd128, 8'd128},
    {1'b0, 2'd1, 3'd1, 2'd2, 8'd80,  8'd90,  8'd200},
    {1'b0, 2'd1, 3'd1, 2'd3, 8'd80,  8'd90,  8'd200},
    {1'b0, 2'd1, 3'd0, 2'd3, 8'd120, 8'd30,  8'd220},
    {1'b0, 2'd1, 3'd7, 2'd2, 8'd60,  8'd150, 8'd100},
    {1'b0, 2'd1, 3'd2, 2'd1, 8'd235, 8'd16,  8'd240},
    // hard mode (R7, R3)
    {1'b1, 2'd3, 3'd0, 2'd3, 8'd40,  8'd50,  8'd60},
    {1'b0, 2'd3, 3'd2, 2'd0, 8'd41,  8'd51,  8'd61},
    {1'b0, 2'd3, 3'd3, 2'd1, 8'd42,  8'd52,  8'd62},
    {1'b0, 2'd3, 3'd0, 2'd2, 8'd43,  8'd53,  8'd63},
    {1'b0, 2'd3, 3'd4, 2'd0, 8'd44,  8'd54,  8'd64},
    {1'b0, 2'd3, 3'd5, 2'd0, 8'd45,  8'd55,  8'd65},
    {1'b0, 2'd3, 3'd6, 2'd0, 8'd46,  8'd56,  8'd66},
    {1'b0, 2'd3, 3'd7, 2'd0, 8'd47,  8'd57,  8'd67},
    {1'b0, 2'd3, 3'd0, 2'd0, 8'd48,  8'd58,  8'd68},
    // internal mode (R8, R9, R10, R11), mix level toggling
    {1'b1, 2'd2, 3'd0, 2'd3, 8'd100, 8'd128, 8'd128},
    {1'b0, 2'd2, 3'd0, 2'd1, 8'd110, 8'd120, 8'd130},
    {1'b0, 2'd2, 3'd1, 2'd3, 8'd120, 8'd110, 8'd140},
    {1'b0, 2'd2, 3'd1, 2'd0, 8'd130, 8'd100, 8'd150},
    {1'b0, 2'd2, 3'd1, 2'd2, 8'd140, 8'd90,  8'd160},
    {1'b0, 2'd2, 3'd1, 2'd1, 8'd150, 8'd80,  8'd170},
    {1'b0, 2'd2, 3'd0, 2'd3, 8'd160, 8'd70,  8'd180},
    {1'b0, 2'd2, 3'd0, 2'd2, 8'd170, 8'd60,  8'd190},
    {1'b0, 2'd2, 3'd0, 2'd0, 8'd180, 8'd50,  8'd200},
    {1'b0, 2'd2, 3'd2, 2'd3, 8'd190, 8'd40,  8'd210},
    {1'b0, 2'd2, 3'd2, 2'd1, 8'd200, 8'd30,  8'd220},
    {1'b0, 2'd2, 3'd2, 2'd2, 8'd210, 8'd20,  8'd230},
    {1'b0, 2'd2, 3'd4, 2'd3, 8'd220, 8'd25,  8'd35},
    {1'b0, 2'd2, 3'd4, 2'd0, 8'd30,  8'd45,  8'd55},
    {1'b0, 2'd2, 3'd4, 2'd1, 8'd60,  8'd75,  8'd85},
    {1'b0, 2'd2, 3'd0, 2'd2, 8'd90,  8'd95,  8'd105},
    {1'b0, 2'd2, 3'd0, 2'd3, 8'd77,  8'd88,  8'd99}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic [2:0] in_code = '0;
  logic [1:0] in_lvl = '0;
  logic out_valid;
  logic [DW-1:0] out_y, out_cb, out_cr;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ovl_mixer_top #(.DW(DW), .CW(3), .LW(2)) dut (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .in_code(in_code), .in_lvl(in_lvl),
    .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  function automatic logic [23:0] pal(input logic [2:0] c, input logic [23:0] pix);
    case (c)
      3'd1: return {8'd35,  8'd212, 8'd114};
      3'd2: return {8'd65,  8'd100, 8'd212};
      3'd3: return {8'd84,  8'd184, 8'd198};
      3'd4: return {8'd112, 8'd72,  8'd58};
      3'd5: return {8'd131, 8'd156, 8'd44};
      3'd6: return {8'd162, 8'd44,  8'd142};
      3'd7: return {8'd235, 8'd128, 8'd128};
      default: return pix;
    endcase
  endfunction

  function automatic logic [23:0] mixw(input logic [23:0] b, input logic [23:0] t, input int w);
    logic [23:0] r;
    for (int k = 0; k < 3; k++) begin
      int bv, tv;
      bv = int'(b[k*8 +: 8]);
      tv = int'(t[k*8 +: 8]);
      r[k*8 +: 8] = 8'((w * tv + (8 - w) * bv + 4) / 8);
    end
    return r;
  endfunction

  function automatic logic [23:0] model(input logic [1:0] md, input logic [2:0] p,
                                        input logic [2:0] c, input logic [2:0] x,
                                        input logic [1:0] lv, input logic [23:0] pix);
    int wtab [4] = '{0, 1, 7, 8};
    case (md)
      2'd1: return (c == 0) ? pix : mixw(pix, pal(c, pix), wtab[lv]);
      2'd3: return (c == 0) ? pix : pal(c, pix);
      2'd2: begin
        if (x != c) return mixw(pal(c, pix), pal(x, pix), 1);
        else if (p != c) return mixw(pal(p, pix), pal(c, pix), 7);
        else return pal(c, pix);
      end
      default: return pix;
    endcase
  endfunction

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid=%0d y=%0d cb=%0d cr=%0d, expected valid=%0d y=%0d cb=%0d cr=%0d",
               req, act[24], act[23:16], act[15:8], act[7:0],
               exp[24], exp[23:16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [2:0] c, input logic [1:0] lv, input logic [23:0] pix);
    @(negedge clk);
    in_valid = 1'b1;
    in_code = c;
    in_lvl = lv;
    {in_y, in_cb, in_cr} = pix;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic [1:0] md);
    case (md)
      2'd0: return "R4 off";
      2'd1: return "R5/R6 external";
      2'd3: return "R7 hard with R3 palette";
      default: return "R8/R9/R10/R11 internal";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pe;
    logic [2:0] prv;
    bit have;
    pe = '0;
    prv = '0;
    have = 1'b0;

    // R1: reset state
    do_reset();
    #1;
    check("R1 reset", {out_valid, out_y, out_cb, out_cr}, 25'd0);

    // R1/R2: single pixel gives no output, result appears after the next one
    mode = 2'd2;
    push(3'd0, 2'd0, {8'd100, 8'd128, 8'd128});
    check("R1 first pixel alone", {out_valid, 24'd0}, 25'd0);
    idle();
    check("R2 idle no output", {out_valid, 24'd0}, 25'd0);
    // R8 hand values: blue edge on pixel (100,128,128)
    push(3'd1, 2'd0, {8'd100, 8'd128, 8'd128});
    check("R8 early 1/8 blue", {out_valid, out_y, out_cb, out_cr},
          {1'b1, 8'd92, 8'd139, 8'd126});
    push(3'd1, 2'd3, {8'd100, 8'd128, 8'd128});
    check("R8 first 7/8 blue", {out_valid, out_y, out_cb, out_cr},
          {1'b1, 8'd43, 8'd202, 8'd116});
    push(3'd1, 2'd1, {8'd100, 8'd128, 8'd128});
    check("R8 full blue", {out_valid, out_y, out_cb, out_cr},
          {1'b1, 8'd35, 8'd212, 8'd114});
    idle();
    check("R2 valid drops after gap", {out_valid, 24'd0}, 25'd0);

    // table-driven scenarios
    for (int i = 0; i < NV; i++) begin
      logic [31:0] e;
      e = VEC[i];
      if (e[31]) begin
        do_reset();
        have = 1'b0;
        prv = '0;
      end
      mode = e[30:29];
      push(e[28:26], e[25:24], e[23:0]);
      if (have) begin
        check(tag_of(pe[30:29]), {out_valid, out_y, out_cb, out_cr},
              {1'b1, model(pe[30:29], prv, pe[28:26], e[28:26], pe[25:24], pe[23:0])});
        prv = pe[28:26];
      end
      pe = e;
      have = 1'b1;
    end
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule